// File: doc/BRIEF.md
# Linear Light-Sensor Readout Sequencer

This block reads one full line from a linear light-sensor array. When a start request arrives, it first accepts and throws away two ADC conversions so that no stale value reaches memory. Next it drives the array's serial-input line and pixel clock through an overlapping four-phase start pulse. It then walks the array one pixel clock at a time, taking one ADC conversion for each pixel.

Each conversion is turned from a signed raw sample into an unsigned 14-bit intensity. Pixels are paired: the even pixel goes in the low half of a 32-bit word and the odd pixel in the high half. The word goes out on a simple write port whose address starts at zero. A one-cycle done flag ends the frame. Every timed phase lasts `PHASE_CLKS` system clocks. Every sample waits for the ADC's valid strobe, so the block works with any conversion latency.

Top module: `lsa_readout`

## Requirements
- R1: While reset is held and while idle, `si_o`, `sclk_o`, `adc_run_o`, `wr_en_o` and `done_o` are all low.
- R2: After a start request is accepted, exactly two cycles with `adc_valid_i` high are consumed and their data discarded before `si_o` rises.
- R3: The start pulse runs in four phases of `PHASE_CLKS` cycles each: SI high with CLK low, then both high, then SI low with CLK high, then both low. SI is therefore high for 2·`PHASE_CLKS` cycles, CLK is high for 2·`PHASE_CLKS` cycles, SI rises while CLK is low, and SI falls while CLK is high.
- R4: Each word is built in this order: capture the even pixel, one pixel clock (`PHASE_CLKS` cycles high, then `PHASE_CLKS` cycles low), capture the odd pixel, write. Exactly one pixel clock therefore comes before each write, and there are `PIXELS/2` pixel clocks per frame.
- R5: Each pixel value is computed as follows: take `adc_data_i[15:0]` as a signed number, shift it arithmetically right by two, and add 0x2000. This gives a value from 0 to 0x3FFF, and bits [31:16] of the ADC word are ignored.
- R6: `wr_data_o[15:0]` holds pixel 2k and `wr_data_o[31:16]` holds pixel 2k+1, each zero-extended to 16 bits.
- R7: A frame makes exactly `PIXELS/2` one-cycle writes, at addresses 0, 1, 2 … in order.
- R8: A capture completes only in a cycle where `adc_valid_i` is high. While valid stays low, the sequence does not advance.
- R9: `adc_run_o` is high for the whole frame, from the cycle after the start is accepted until the done cycle. This covers every cycle in which SI, CLK or a write is active.
- R10: `done_o` is high for exactly one cycle, the cycle right after the last write. The block is idle again in the following cycle.
- R11: A start request during a frame is ignored. The frame still makes exactly `PIXELS/2` writes and one done, and no new frame follows.
- R12: A new frame after done starts again at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Frame request, accepted only while idle |
| adc_valid_i | input | 1 | ADC conversion strobe |
| adc_data_i | input | 32 | ADC word; only bits [15:0] are used |
| si_o | output | 1 | Serial-input start pulse to the array |
| sclk_o | output | 1 | Pixel clock to the array |
| adc_run_o | output | 1 | ADC run/enable, high during a frame |
| wr_en_o | output | 1 | Frame memory write strobe |
| wr_addr_o | output | 7 | Word address (clog2 of PIXELS/2) |
| wr_data_o | output | 32 | Packed pixel pair |
| done_o | output | 1 | One-cycle end-of-frame flag |

## Verification
`si_o` rises in the cycle after the second flush strobe is taken. Each SI or CLK level then holds for exactly `PHASE_CLKS` cycles per phase. A write appears one cycle after the strobe that captures the odd pixel, and `done_o` comes one cycle after the last write. The bench therefore checks nothing at a fixed delay from start. It samples on the falling edge, measures every high time by counting cycles between observed edges, and ties each write to the pixel index that its own ADC model had on offer when the capture strobes were consumed. A pass with valid held low and a pass with valid pulsing once every three cycles show that the spacing follows the strobe and not a timer.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int PIX_W = 16;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FLUSH0, ST_FLUSH1,
    ST_SI_A, ST_SI_B, ST_SI_C, ST_SI_D,
    ST_CAP_LO, ST_CLK_H, ST_CLK_L, ST_CAP_HI,
    ST_WRITE, ST_DONE
  } seq_state_e;

  // signed 16-bit sample -> offset unsigned 14-bit intensity, zero-extended
  function automatic logic [PIX_W-1:0] conv_pixel(input logic [15:0] raw);
    logic signed [15:0] s;
    s = $signed(raw) >>> 2;
    return PIX_W'(s + 16'sh2000);
  endfunction
endpackage

// File: rtl/lsa_phase_timer.sv
module lsa_phase_timer #(
  parameter int PHASE_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = (PHASE_CLKS < 2) ? 1 : $clog2(PHASE_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || expire) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lsa_pair_packer.sv
module lsa_pair_packer
  import lsa_pkg::*;
#(
  parameter int ADC_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_lo,
  input  logic               take_hi,
  input  logic [ADC_W-1:0]   raw,
  output logic [2*PIX_W-1:0] word
);
  logic [PIX_W-1:0] lo_q, hi_q;
  logic             unused_raw_hi;

  assign unused_raw_hi = ^raw[ADC_W-1:16];
  assign word = {hi_q, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (take_lo) lo_q <= conv_pixel(raw[15:0]);
      if (take_hi) hi_q <= conv_pixel(raw[15:0]);
    end
  end
endmodule

// File: rtl/lsa_readout.sv
module lsa_readout
  import lsa_pkg::*;
#(
  parameter int PIXELS     = 256,
  parameter int PHASE_CLKS = 2,
  parameter int ADC_W      = 32,
  localparam int NUM_WORDS = PIXELS / 2,
  localparam int ADDR_W    = $clog2(NUM_WORDS),
  localparam int WORD_W    = 2 * PIX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              adc_valid_i,
  input  logic [ADC_W-1:0]  adc_data_i,
  output logic              si_o,
  output logic              sclk_o,
  output logic              adc_run_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(NUM_WORDS - 1);

  seq_state_e        state, nstate;
  logic [ADDR_W-1:0] word_cnt;
  logic              phase_run, phase_end;

  // named events for the checker
  logic frame_active, take_lo, take_hi, word_last;

  assign frame_active = (state != ST_IDLE);
  assign take_lo      = (state == ST_CAP_LO) && adc_valid_i;
  assign take_hi      = (state == ST_CAP_HI) && adc_valid_i;
  assign word_last    = (word_cnt == LAST_WORD);
  assign phase_run    = state inside {ST_SI_A, ST_SI_B, ST_SI_C, ST_SI_D,
                                      ST_CLK_H, ST_CLK_L};

  lsa_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(phase_run), .expire(phase_end)
  );

  lsa_pair_packer #(.ADC_W(ADC_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .take_lo(take_lo), .take_hi(take_hi),
    .raw(adc_data_i), .word(wr_data_o)
  );

  always_comb begin
    nstate = state;
    unique case (state)
      ST_IDLE:   if (start_i)     nstate = ST_FLUSH0;
      ST_FLUSH0: if (adc_valid_i) nstate = ST_FLUSH1;
      ST_FLUSH1: if (adc_valid_i) nstate = ST_SI_A;
      ST_SI_A:   if (phase_end)   nstate = ST_SI_B;
      ST_SI_B:   if (phase_end)   nstate = ST_SI_C;
      ST_SI_C:   if (phase_end)   nstate = ST_SI_D;
      ST_SI_D:   if (phase_end)   nstate = ST_CAP_LO;
      ST_CAP_LO: if (take_lo)     nstate = ST_CLK_H;
      ST_CLK_H:  if (phase_end)   nstate = ST_CLK_L;
      ST_CLK_L:  if (phase_end)   nstate = ST_CAP_HI;
      ST_CAP_HI: if (take_hi)     nstate = ST_WRITE;
      ST_WRITE:  nstate = word_last ? ST_DONE : ST_CAP_LO;
      ST_DONE:   nstate = ST_IDLE;
      default:   nstate = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      word_cnt <= '0;
    end else begin
      state <= nstate;
      if (state == ST_IDLE)       word_cnt <= '0;
      else if (state == ST_WRITE) word_cnt <= word_cnt + 1'b1;
    end
  end

  assign si_o      = state inside {ST_SI_A, ST_SI_B};
  assign sclk_o    = state inside {ST_SI_B, ST_SI_C, ST_CLK_H};
  assign adc_run_o = frame_active;
  assign wr_en_o   = (state == ST_WRITE);
  assign wr_addr_o = word_cnt;
  assign done_o    = (state == ST_DONE);
endmodule

// File: rtl/lsa_readout_chk.sv
module lsa_readout_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              si_o,
  input logic              sclk_o,
  input logic              adc_run_o,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              done_o,
  input logic              frame_active
);
  logic [ADDR_W-1:0] last_addr;
  logic              have_last;

  always_ff @(posedge clk) begin
    if (!rst_n || done_o) begin
      have_last <= 1'b0;
      last_addr <= '0;
    end else if (wr_en_o) begin
      have_last <= 1'b1;
      last_addr <= wr_addr_o;
    end
  end

  // R3
  si_rise_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(si_o) |-> !sclk_o);
  // R3
  si_fall_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(si_o) |-> sclk_o);
  // R9
  run_covers_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (si_o || sclk_o || wr_en_o) |-> adc_run_o);
  // R7
  write_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);
  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && have_last) |-> (wr_addr_o == ADDR_W'(last_addr + 1'b1)));
  // R12
  addr_first_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && !have_last) |-> (wr_addr_o == '0));
  // R10
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(wr_en_o));
  // R10
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !frame_active));
  // R4
  write_not_during_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (!si_o && !sclk_o));
endmodule

bind lsa_readout lsa_readout_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .si_o(si_o), .sclk_o(sclk_o),
  .adc_run_o(adc_run_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
  .done_o(done_o), .frame_active(frame_active)
);

// File: tb/lsa_readout_bench.sv
module lsa_readout_bench;
  localparam int PIXELS = 256;
  localparam int D      = 3;
  localparam int NW     = PIXELS / 2;
  localparam int AW     = $clog2(NW);

  // {raw sample[15:0], expected pixel[15:0]} (R5)
  localparam logic [31:0] VEC [8] = '{
    {16'h0000, 16'h2000}, {16'h7FFF, 16'h3FFF},
    {16'h8000, 16'h0000}, {16'hFFFF, 16'h1FFF},
    {16'h0004, 16'h2001}, {16'hFFFC, 16'h1FFF},
    {16'h1234, 16'h248D}, {16'hC000, 16'h1000}
  };

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic adc_valid_i;
  logic [31:0] adc_data_i;
  logic si_o, sclk_o, adc_run_o, wr_en_o, done_o;
  logic [AW-1:0] wr_addr_o;
  logic [31:0] wr_data_o;

  int n_run = 0, n_fail = 0;
  int vmode = 0, cyc = 0, pix = 0;
  bit in_frame = 0, si_done = 0, start_pulse = 0, p_si = 0, p_sclk = 0, p_wlast = 0;
  int vcnt, si_len, cl_len, rises, tot_rises, wr, dn;

  always #5 clk = ~clk;

  lsa_readout #(.PIXELS(PIXELS), .PHASE_CLKS(D)) u_lsa_readout (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .adc_valid_i(adc_valid_i),
    .adc_data_i(adc_data_i), .si_o(si_o), .sclk_o(sclk_o), .adc_run_o(adc_run_o),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .done_o(done_o)
  );

  function automatic logic [15:0] exp_pix(input int p);
    return VEC[p % 8][15:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ADC model: upper half carries junk that must be ignored (R5)
  initial begin
    adc_valid_i = 1'b0;
    adc_data_i  = '0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      adc_valid_i = (vmode == 0) ? 1'b1 : (vmode == 1) ? (cyc % 3 == 0) : 1'b0;
      adc_data_i  = {pix[15:0] ^ 16'hA5A5, VEC[pix % 8][31:16]};
    end
  end

  // monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (start_i && !in_frame) begin
        in_frame = 1; si_done = 0; pix = 0; vcnt = 0; rises = 0;
        tot_rises = 0; wr = 0; dn = 0; si_len = 0; cl_len = 0;
      end else if (in_frame) begin
        if (si_o && !p_si) begin
          chk(!sclk_o, "R3 SI rises with CLK low", sclk_o, 0);
          chk(vcnt == 2, "R2 flush strobes before SI", vcnt, 2);
          si_len = 0;
        end
        if (!si_o && p_si) begin
          chk(sclk_o, "R3 SI falls with CLK high", sclk_o, 1);
          chk(si_len == 2 * D, "R3 SI high length", si_len, 2 * D);
          si_done = 1; rises = 0;
        end
        if (si_o) si_len++;
        if (!si_o && !si_done && adc_valid_i) vcnt++;
        if (sclk_o && !p_sclk) begin
          chk(si_o == !si_done, "R3 CLK rise phase vs SI", si_o, !si_done);
          chk(adc_run_o, "R9 run high while clocking", adc_run_o, 1);
          start_pulse = si_o; cl_len = 0;
          if (si_done) begin rises++; tot_rises++; pix++; end
        end
        if (!sclk_o && p_sclk)
          chk(cl_len == (start_pulse ? 2 * D : D), "R3 R4 CLK high length",
              cl_len, start_pulse ? 2 * D : D);
        if (sclk_o) cl_len++;
        if (done_o) begin
          chk(p_wlast, "R10 done right after last write", p_wlast, 1);
          dn++; in_frame = 0;
        end
        p_wlast = 0;
        if (wr_en_o) begin
          chk(wr_addr_o == AW'(wr), "R7 R12 write address", wr_addr_o, wr);
          chk(wr_data_o[15:0] == exp_pix(2 * wr), "R5 R6 low half pixel", wr_data_o[15:0], exp_pix(2 * wr));
          chk(wr_data_o[31:16] == exp_pix(2 * wr + 1), "R5 R6 high half pixel", wr_data_o[31:16], exp_pix(2 * wr + 1));
          chk(rises == 1, "R4 one pixel clock per word", rises, 1);
          rises = 0; wr++; pix++;
          p_wlast = (wr == NW);
        end
      end
    end
    p_si = si_o; p_sclk = sclk_o;
  end

  task automatic pulse_start();
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
  endtask

  task automatic wait_frame();
    int t;
    for (t = 0; t < 30000; t++) begin
      @(negedge clk);
      if (!in_frame) break;
    end
    chk(t < 30000, "watchdog frame end", t, 30000);
  endtask

  task automatic frame_totals(input string tag);
    chk(wr == NW, {tag, " R7 write count"}, wr, NW);
    chk(dn == 1, {tag, " R10 done count"}, dn, 1);
    chk(tot_rises == NW, {tag, " R4 pixel clock count"}, tot_rises, NW);
    repeat (20) @(negedge clk);
    chk(!adc_run_o && !si_o && !sclk_o, {tag, " R11 R9 idle after frame"}, {adc_run_o, si_o, sclk_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!si_o, "R1 reset si", si_o, 0);
    chk(!sclk_o, "R1 reset sclk", sclk_o, 0);
    chk(!adc_run_o, "R1 reset run", adc_run_o, 0);
    chk(!wr_en_o, "R1 reset write", wr_en_o, 0);
    chk(!done_o, "R1 reset done", done_o, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!adc_run_o && !wr_en_o, "R1 idle without start", {adc_run_o, wr_en_o}, 0);

    // frame 1: valid always high, extra start mid-frame (R11)
    vmode = 0;
    pulse_start();
    repeat (200) @(posedge clk);
    pulse_start();
    wait_frame();
    frame_totals("frame1");

    // frame 2: valid held off, then sparse strobes (R8, R12)
    vmode = 2;
    pulse_start();
    repeat (30) @(negedge clk);
    chk(!si_o && !sclk_o && adc_run_o, "R8 stalls without valid", {si_o, sclk_o, adc_run_o}, 1);
    chk(vcnt == 0, "R8 no strobes seen", vcnt, 0);
    vmode = 1;
    wait_frame();
    frame_totals("frame2");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule